// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers a set of interrupt request lines into a single processor interrupt. The lowest sixteen lines are internal, always active-high and always caught on a rising edge. Above them sit up to sixteen external lines. Their count is a parameter, and so is the polarity and trigger style of each one. Every line is first brought to active-high form. It is then caught either on a rising edge or for as long as it is asserted. The catch lands in a sticky status bit.

Software talks to the block through a small word-wide register window. It reads the status bits and the pending bits, where pending is status masked by enable. It writes the enable mask. It clears caught events by writing ones to an acknowledge register. A level-style line that is still asserted when acknowledged is caught again in the same update, so an acknowledge cannot lose it. The interrupt output is high whenever any pending bit is set.

Top module: `trig_irq_ctrl`

## Requirements
- R1: Lines 0 to 15 are active-high and rising-edge caught: a 0-to-1 change sets the status bit at the next clock edge, and holding the line high sets nothing further.
- R2: An external line (index 16 + k) whose bit k of EXT_POS_CFG is 0 is active-low: a low input counts as asserted. When that bit is 1, the line is active-high.
- R3: An external line whose bit k of EXT_EDGE_CFG is 1 sets its status bit only when its active-high form goes from 0 to 1. The status bit then stays set after the line returns to idle.
- R4: An external line whose bit k of EXT_EDGE_CFG is 0 sets its status bit on every clock in which its active-high form is 1. An acknowledge issued while it is asserted leaves the bit set.
- R5: Pending is status AND enable, and irq_out is the OR of all pending bits. A status bit whose enable bit is 0 stays recorded but does not raise irq_out.
- R6: A write to offset 0x3C clears exactly the status bits written as 1. Bits written as 0, and bits not currently set, are unaffected. If a new event arrives on a bit in the same cycle as its acknowledge, the bit stays set.
- R7: A write to offset 0x38 loads the enable mask. Pending and irq_out follow it from the next cycle. Only bits 0 to 16+EXT_COUNT-1 are stored, and higher bits read as 0.
- R8: Reads return status at 0x30, pending at 0x34 and enable at 0x38. Offsets 0x0C and 0x3C read 0. Writes to 0x30 and 0x34 change nothing.
- R9: An access whose address bits [1:0] are not 00 is ignored: a write has no effect and a read returns 0.
- R10: Synchronous reset clears status, enable and the stored previous input samples, and holds irq_out low. A line that is high when reset ends is therefore seen as a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 16+EXT_COUNT | Raw interrupt request lines |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A vector table drives a configuration with one external line of each polarity and trigger combination. An internal pulse held high tells edge catching apart from level catching. An active-low edge line separates inversion from a missing inversion. Acknowledging an active-low level line while it is still asserted, and again after it drops, shows re-arming against a true clear. Further patterns acknowledge one bit of two, acknowledge a bit that is not set, and acknowledge a bit in the same cycle its edge arrives. Directed steps cover enable masking, status that cannot be written, misaligned access, and a line held high across reset.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

    localparam int INT_SRC  = 16;
    localparam int MAX_EXT  = 16;
    localparam int REG_W    = 32;
    localparam int BUS_AW   = 8;

    localparam logic [BUS_AW-1:0] OFS_MODE   = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h30;
    localparam logic [BUS_AW-1:0] OFS_PEND   = 8'h34;
    localparam logic [BUS_AW-1:0] OFS_EN     = 8'h38;
    localparam logic [BUS_AW-1:0] OFS_ACK    = 8'h3C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_STATUS,
        SEL_PEND,
        SEL_EN,
        SEL_ACK
    } reg_sel_e;

    typedef struct packed {
        logic             ack_we;
        logic             en_we;
        logic [REG_W-1:0] data;
    } reg_cmd_t;

    // Word-only decode: any misaligned address selects nothing.
    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            unique case (a)
                OFS_MODE:   s = SEL_MODE;
                OFS_STATUS: s = SEL_STATUS;
                OFS_PEND:   s = SEL_PEND;
                OFS_EN:     s = SEL_EN;
                OFS_ACK:    s = SEL_ACK;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/trig_src_detect.sv
module trig_src_detect #(
    parameter int               NSRC      = 20,
    parameter logic [NSRC-1:0]  EDGE_MASK = '1,
    parameter logic [NSRC-1:0]  POS_MASK  = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raw_in,
    output logic [NSRC-1:0] event_o
);

    logic [NSRC-1:0] norm;
    logic [NSRC-1:0] prev_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Polarity normalisation
        if (POS_MASK[i]) begin : g_hi
            assign norm[i] = raw_in[i];
        end else begin : g_lo
            assign norm[i] = ~raw_in[i];
        end

        // Trigger style
        if (EDGE_MASK[i]) begin : g_edge
            assign event_o[i] = norm[i] & ~prev_q[i];
        end else begin : g_level
            assign event_o[i] = norm[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= norm;
    end

endmodule

// File: rtl/trig_status_bank.sv
module trig_status_bank
    import trig_irq_pkg::*;
#(
    parameter int NSRC = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] event_i,
    input  reg_cmd_t        cmd,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] enable_o,
    output logic [NSRC-1:0] pending_o
);

    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] clr_mask;

    assign clr_mask = cmd.ack_we ? cmd.data[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            if (cmd.en_we) enable_q <= cmd.data[NSRC-1:0];
            // New events are ORed after the clear so they win over it,
            // and asserted level lines re-arm in the same update.
            status_q <= (status_q & ~clr_mask) | event_i;
        end
    end

    assign status_o  = status_q;
    assign enable_o  = enable_q;
    assign pending_o = status_q & enable_q;

endmodule

// File: rtl/trig_regif.sv
module trig_regif
    import trig_irq_pkg::*;
#(
    parameter int NSRC = 20
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [NSRC-1:0]   status_i,
    input  logic [NSRC-1:0]   pending_i,
    input  logic [NSRC-1:0]   enable_i,
    output reg_cmd_t          cmd,
    output logic [REG_W-1:0]  bus_rdata
);

    reg_sel_e sel;

    assign sel = decode_addr(bus_addr);

    always_comb begin
        cmd.ack_we = bus_we && (sel == SEL_ACK);
        cmd.en_we  = bus_we && (sel == SEL_EN);
        cmd.data   = bus_wdata;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: bus_rdata = REG_W'(status_i);
            SEL_PEND:   bus_rdata = REG_W'(pending_i);
            SEL_EN:     bus_rdata = REG_W'(enable_i);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
    import trig_irq_pkg::*;
#(
    parameter int          EXT_COUNT    = 4,
    parameter logic [15:0] EXT_EDGE_CFG = 16'h0005,
    parameter logic [15:0] EXT_POS_CFG  = 16'h0003
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [REG_W-1:0]             bus_wdata,
    output logic [REG_W-1:0]             bus_rdata,
    input  logic [INT_SRC+EXT_COUNT-1:0] src_in,
    output logic                         irq_out
);

    localparam int NUM_SRC = INT_SRC + EXT_COUNT;
    localparam logic [NUM_SRC-1:0] EDGE_ALL = NUM_SRC'({EXT_EDGE_CFG, 16'hFFFF});
    localparam logic [NUM_SRC-1:0] POS_ALL  = NUM_SRC'({EXT_POS_CFG, 16'hFFFF});

    initial begin
        if (EXT_COUNT < 1 || EXT_COUNT > MAX_EXT)
            $error("EXT_COUNT out of range");
    end

    logic [NUM_SRC-1:0] events;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pending;
    reg_cmd_t           cmd;

    trig_src_detect #(
        .NSRC      (NUM_SRC),
        .EDGE_MASK (EDGE_ALL),
        .POS_MASK  (POS_ALL)
    ) u_detect (
        .clk     (clk),
        .rst     (rst),
        .raw_in  (src_in),
        .event_o (events)
    );

    trig_status_bank #(.NSRC(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .event_i   (events),
        .cmd       (cmd),
        .status_o  (status_q),
        .enable_o  (enable_q),
        .pending_o (pending)
    );

    trig_regif #(.NSRC(NUM_SRC)) u_regif (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .status_i  (status_q),
        .pending_i (pending),
        .enable_i  (enable_q),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    assign irq_out = |pending;

endmodule

// File: rtl/trig_irq_ctrl_chk.sv
module trig_irq_ctrl_chk #(
    parameter int NSRC = 20
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      bus_addr,
    input logic            bus_we,
    input logic [31:0]     bus_wdata,
    input logic [NSRC-1:0] src_in,
    input logic            irq_out,
    input logic [NSRC-1:0] status_q,
    input logic [NSRC-1:0] enable_q
);

    logic [15:0] prev_in_q;
    logic [15:0] rise;

    always_ff @(posedge clk) begin
        if (rst) prev_in_q <= '0;
        else     prev_in_q <= src_in[15:0];
    end

    assign rise = src_in[15:0] & ~prev_in_q;

    // R1 / R3: a rising internal line is recorded at the next edge
    assert_edge_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (rise != 16'h0) |=> ((status_q[15:0] & $past(rise)) == $past(rise)));

    // R5: nothing enabled means no interrupt
    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (enable_q == '0) |-> !irq_out);

    // R5: nothing recorded means no interrupt
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (status_q == '0) |-> !irq_out);

    // R6: acknowledged internal bits with their line low are cleared
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h3C)
        |=> ((status_q[15:0] & $past(bus_wdata[15:0] & ~src_in[15:0])) == 16'h0));

    // R10: the cycle after reset shows a clean state
    assert_reset_clean_R10: assert property (@(posedge clk)
        $past(rst) |-> (status_q == '0 && enable_q == '0 && !irq_out));

endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk #(.NSRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .src_in    (src_in),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .enable_q  (enable_q)
);

// File: tb/test_trig_irq_ctrl.sv
module test_trig_irq_ctrl;

    localparam int NS = 20;
    // ext0 (bit16): edge, high   ext1 (bit17): level, high
    // ext2 (bit18): edge, low    ext3 (bit19): level, low
    localparam logic [NS-1:0] IDLE = 20'hC0000;

    // {src_in, ack data (0 = no write), expected status}
    localparam int NV = 19;
    localparam logic [71:0] VEC [NV] = '{
        {20'hC0000, 32'h00000000, 20'h00000},
        {20'hC0001, 32'h00000000, 20'h00001},
        {20'hC0001, 32'h00000000, 20'h00001},
        {20'hC0001, 32'h00000001, 20'h00000},
        {20'hC0000, 32'h00000000, 20'h00000},
        {20'hD0000, 32'h00000000, 20'h10000},
        {20'h80000, 32'h00000000, 20'h50000},
        {20'h80000, 32'h00010000, 20'h40000},
        {20'hE0000, 32'h00000000, 20'h60000},
        {20'hE0000, 32'h00020000, 20'h60000},
        {20'hC0000, 32'h00020000, 20'h40000},
        {20'h40000, 32'h00000000, 20'hC0000},
        {20'hC0000, 32'hFFFFFFFF, 20'h00000},
        {20'hC0020, 32'h00000020, 20'h00020},
        {20'hC0000, 32'h00000001, 20'h00020},
        {20'hC0000, 32'h00000020, 20'h00000},
        {20'hC0003, 32'h00000000, 20'h00003},
        {20'hC0000, 32'h00000002, 20'h00001},
        {20'hC0000, 32'h00000001, 20'h00000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = 8'h0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_in = IDLE;
    logic          irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trig_irq_ctrl i_trig_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        rd(8'h30, r); check("R10 status after reset", r, 32'h0);
        rd(8'h34, r); check("R10 pending after reset", r, 32'h0);
        rd(8'h38, r); check("R10 enable after reset", r, 32'h0);
        check("R10 irq after reset", {31'h0, irq_out}, 32'h0);
        rd(8'h0C, r); check("R8 mode reads zero", r, 32'h0);

        // R7: enable stores only implemented bits
        wr(8'h38, 32'hFFFFFFFF);
        rd(8'h38, r); check("R7 enable readback", r, 32'h000FFFFF);

        // Table: R1 R2 R3 R4 R6 with everything enabled (R5)
        for (int i = 0; i < NV; i++) begin
            src_in = VEC[i][71:52];
            if (VEC[i][51:20] != 32'h0) wr(8'h3C, VEC[i][51:20]);
            else @(negedge clk);
            rd(8'h30, r);
            check($sformatf("R1 R2 R3 R4 R6 table step %0d status", i), r, {12'h0, VEC[i][19:0]});
            check($sformatf("R5 table step %0d irq", i), {31'h0, irq_out},
                  {31'h0, |VEC[i][19:0]});
        end

        // R5: masked status is held but quiet
        wr(8'h38, 32'h0);
        src_in = IDLE | 20'h00080; @(negedge clk);
        src_in = IDLE;             @(negedge clk);
        rd(8'h30, r); check("R5 masked status held", r, 32'h80);
        rd(8'h34, r); check("R5 masked pending zero", r, 32'h0);
        check("R5 masked irq low", {31'h0, irq_out}, 32'h0);
        wr(8'h38, 32'h80);
        rd(8'h34, r); check("R7 pending after enable write", r, 32'h80);
        check("R7 irq after enable write", {31'h0, irq_out}, 32'h1);
        wr(8'h3C, 32'h80);
        check("R6 irq after ack", {31'h0, irq_out}, 32'h0);

        // R8: status and pending are not writable; ack reads zero
        src_in = IDLE | 20'h00100; @(negedge clk);
        src_in = IDLE;
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);
        rd(8'h30, r); check("R8 status write ignored", r, 32'h100);
        rd(8'h3C, r); check("R8 ack reads zero", r, 32'h0);

        // R9: misaligned access ignored
        wr(8'h3D, 32'h100);
        rd(8'h30, r); check("R9 misaligned ack ignored", r, 32'h100);
        rd(8'h31, r); check("R9 misaligned read zero", r, 32'h0);
        wr(8'h3C, 32'h100);

        // R10: reset mid-run, with a line held high across it
        wr(8'h38, 32'hFFFFFFFF);
        src_in = IDLE | 20'h00200; @(negedge clk);
        check("R10 irq before reset", {31'h0, irq_out}, 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h30, r); check("R10 status in reset", r, 32'h0);
        check("R10 irq in reset", {31'h0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd(8'h38, r); check("R10 enable cleared", r, 32'h0);
        rd(8'h30, r); check("R10 held line seen as new edge", r, 32'h200);
        check("R10 irq low with enable cleared", {31'h0, irq_out}, 32'h0);

        finish_run();
    end

endmodule